// File: doc/BRIEF.md
# Level Interrupt Funnel with Latched Sources

This block gathers a bank of external interrupt lines into a single request line for a parent interrupt controller. Each input is brought into the local clock domain. A rising edge on an input then latches a pending flag for that source. The pending flag stays set until software acknowledges it, even if the input falls again in the meantime.

Software reaches the block through a plain single-cycle read/write port with 32-bit data. Three registers are mapped. The mask register blocks a source when its bit is 1. The acknowledge register is written to 1 and then back to 0 to retire a source. The status register shows every pending source that is not masked, all in the same read, and software services the set bits from the lowest index upward. The request output is the OR of the status bits, registered once.

Top module: `irq_funnel`

## Requirements
- R1: After reset the mask register (byte offset 0x14) reads 0xFFFFFFFF, the acknowledge register (offset 0x10) and the status register (offset 0x1C) read 0, and `irq_o` is 0.
- R2: The mask register reads back exactly the last 32-bit value written to offset 0x14.
- R3: The acknowledge register reads back exactly the last value written to offset 0x10.
- R4: A low-to-high transition on `src_i[n]` sets status bit n at the third rising clock edge after the input changes. The bit stays set after the input returns low.
- R5: Status bit n equals pending[n] AND NOT mask[n]. A pending source that is masked is kept, and it shows in status once its mask bit is written to 0.
- R6: Several pending, unmasked sources appear together in one status read.
- R7: Writing 1 and then 0 to bit n of the acknowledge register clears pending[n]. While that bit is 1, rising edges on `src_i[n]` are discarded.
- R8: An input that is still high after its acknowledge does not set pending again. Only a new rising edge sets it.
- R9: `irq_o` equals the OR of the status bits as they stood one clock earlier.
- R10: Reads of any offset other than 0x10, 0x14 and 0x1C return 0, and writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 32 | External interrupt lines, asynchronous |
| bus_we_i | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr_i | input | 8 | Byte offset of the register accessed |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Registered request to the parent controller |

## Verification
Two things can land on one source in the same cycle: an active acknowledge bit, which holds the pending flag at zero, and a freshly detected rising edge, which would set it. The bench sets the acknowledge bit first, raises the input while the bit is held, and then releases it. The status read must then show the source as not pending, because the hold has to win. The random phase mixes source rises, mask rewrites and acknowledges across all 32 bits. Each status read is compared with a bench model of pending AND NOT mask.

// File: rtl/irq_funnel_pkg.sv
package irq_funnel_pkg;
  localparam int unsigned NSRC_DEF = 32;
  localparam logic [7:0] OFS_ACK  = 8'h10;
  localparam logic [7:0] OFS_MASK = 8'h14;
  localparam logic [7:0] OFS_STAT = 8'h1C;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ACK  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stage_d[g] = d_i;
    end else begin : g_next
      assign stage_d[g] = stage_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= '0;
      else         stage_q[g] <= stage_d[g];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] hold_clr_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;

  for (genvar n = 0; n < W; n++) begin : g_src
    always_comb begin
      rise_o[n] = sync_i[n] & ~prev_q[n];
      if (hold_clr_i[n])  pend_d[n] = 1'b0;
      else if (rise_o[n]) pend_d[n] = 1'b1;
      else                pend_d[n] = pend_q[n];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= sync_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_funnel_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      pend_i,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      ack_o,
  output logic [W-1:0]      status_o,
  output logic [W-1:0]      rdata_o
);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  reg_sel_e     sel;
  logic [W-1:0] mask_q, mask_d;
  logic [W-1:0] ack_q, ack_d;
  logic         mask_en, ack_en;

  always_comb begin
    unique case (addr_i)
      A_ACK:   sel = SEL_ACK;
      A_MASK:  sel = SEL_MASK;
      A_STAT:  sel = SEL_STAT;
      default: sel = SEL_NONE;
    endcase
  end

  assign mask_en = we_i && (sel == SEL_MASK);
  assign ack_en  = we_i && (sel == SEL_ACK);
  assign mask_d  = wdata_i;
  assign ack_d   = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      ack_q  <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (ack_en)  ack_q  <= ack_d;
    end
  end

  assign status_o = pend_i & ~mask_q;
  assign mask_o   = mask_q;
  assign ack_o    = ack_q;

  always_comb begin
    unique case (sel)
      SEL_ACK:  rdata_o = ack_q;
      SEL_MASK: rdata_o = mask_q;
      SEL_STAT: rdata_o = status_o;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_funnel.sv
module irq_funnel
  import irq_funnel_pkg::*;
#(
  parameter int unsigned NSRC     = NSRC_DEF,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NSRC-1:0]   bus_wdata_i,
  output logic [NSRC-1:0]   bus_rdata_o,
  output logic              irq_o
);
  logic [1:0]      rst_pipe_q;
  logic            rst_sync_n;
  logic [NSRC-1:0] src_sync;
  logic [NSRC-1:0] rise_w;
  logic [NSRC-1:0] pend_w;
  logic [NSRC-1:0] mask_w;
  logic [NSRC-1:0] ack_w;
  logic [NSRC-1:0] status_w;
  logic            irq_d, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  irq_sync #(.W(NSRC), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .d_i   (src_i),
    .q_o   (src_sync)
  );

  irq_edge_pend #(.W(NSRC)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .sync_i    (src_sync),
    .hold_clr_i(ack_w),
    .rise_o    (rise_w),
    .pend_o    (pend_w)
  );

  irq_regs #(.W(NSRC), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .pend_i  (pend_w),
    .mask_o  (mask_w),
    .ack_o   (ack_w),
    .status_o(status_w),
    .rdata_o (bus_rdata_o)
  );

  assign irq_d = |status_w;

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_funnel_chk.sv
module irq_funnel_chk
  import irq_funnel_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      wdata_i,
  input logic [W-1:0]      rdata_i,
  input logic [W-1:0]      rise_i,
  input logic [W-1:0]      pend_i,
  input logic [W-1:0]      mask_i,
  input logic [W-1:0]      ack_i,
  input logic              irq_i
);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  p_mask_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_MASK) |=> (mask_i == $past(wdata_i)));

  p_ack_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_ACK) |=> (ack_i == $past(wdata_i)));

  p_set_needs_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & ~$past(pend_i) & ~$past(rise_i)) == '0));

  p_status_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_STAT) |-> (rdata_i == (pend_i & ~mask_i)));

  p_ack_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i != '0) |=> ((pend_i & $past(ack_i)) == '0));

  p_irq_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 (irq_i == $past(|(pend_i & ~mask_i))));

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != A_ACK && addr_i != A_MASK && addr_i != A_STAT) |-> (rdata_i == '0));
endmodule

bind irq_funnel irq_funnel_chk #(.W(NSRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_sync_n),
  .we_i   (bus_we_i),
  .addr_i (bus_addr_i),
  .wdata_i(bus_wdata_i),
  .rdata_i(bus_rdata_o),
  .rise_i (rise_w),
  .pend_i (pend_w),
  .mask_i (mask_w),
  .ack_i  (ack_w),
  .irq_i  (irq_o)
);

// File: tb/irq_funnel_bench.sv
`timescale 1ns/1ps
module irq_funnel_bench;
  localparam logic [7:0] A_ACK  = 8'h10;
  localparam logic [7:0] A_MASK = 8'h14;
  localparam logic [7:0] A_STAT = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] src;
  logic        we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] m_pend;
  logic [31:0] m_mask;

  always #2 clk = ~clk;

  irq_funnel u_irq_funnel (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] exp_status(input logic [31:0] p, input logic [31:0] m);
    return p & ~m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    we = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] r, a, m;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; src = '0; we = 1'b0; addr = '0; wdata = '0;
    settle(4);
    rst_n = 1'b1;
    settle(4);

    // R1 reset state
    rd(A_MASK, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    rd(A_ACK, d);  chk("R1 ack", d, 32'h0);
    rd(A_STAT, d); chk("R1 status", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 mask read-back
    wr(A_MASK, 32'hA5A5_0F0F); rd(A_MASK, d); chk("R2 pattern", d, 32'hA5A5_0F0F);
    wr(A_MASK, 32'h0);         rd(A_MASK, d); chk("R2 zero", d, 32'h0);

    // R4/R9 exact latency on bit 3
    @(negedge clk); addr = A_STAT; src[3] = 1'b1;
    settle(2); #1 chk("R4 not before third edge", rdata, 32'h0);
    settle(1); #1 chk("R4 third edge", rdata, 32'h8);
    chk("R9 irq one cycle later", {31'b0, irq}, 32'h0);
    settle(1); #1 chk("R9 irq set", {31'b0, irq}, 32'h1);
    src[3] = 1'b0; settle(5);
    rd(A_STAT, d); chk("R4 latched after fall", d, 32'h8);

    // R3 and R7 acknowledge
    wr(A_ACK, 32'h8); rd(A_ACK, d); chk("R3 ack readback", d, 32'h8);
    wr(A_ACK, 32'h0); rd(A_STAT, d); chk("R7 cleared", d, 32'h0);
    settle(1); #1 chk("R9 irq drop", {31'b0, irq}, 32'h0);

    // R7 hold versus rising edge on bit 4
    wr(A_ACK, 32'h10);
    @(negedge clk); src[4] = 1'b1; settle(6);
    wr(A_ACK, 32'h0); settle(2);
    rd(A_STAT, d); chk("R7 edge under hold lost", d, 32'h0);
    src[4] = 1'b0; settle(4); src[4] = 1'b1; settle(5);
    rd(A_STAT, d); chk("R7 new edge after release", d, 32'h10);

    // R8 high level after acknowledge
    wr(A_ACK, 32'h10); wr(A_ACK, 32'h0); settle(5);
    rd(A_STAT, d); chk("R8 no relatch on level", d, 32'h0);
    src[4] = 1'b0;

    // R5 masked pending retained
    wr(A_MASK, 32'h40);
    @(negedge clk); src[6] = 1'b1; settle(5);
    rd(A_STAT, d); chk("R5 hidden", d, 32'h0);
    chk("R5 irq low", {31'b0, irq}, 32'h0);
    wr(A_MASK, 32'h0); rd(A_STAT, d); chk("R5 revealed", d, 32'h40);
    src[6] = 1'b0;

    // R10 unmapped offsets
    wr(8'h18, 32'h1234_5678); wr(8'h00, 32'hFFFF_FFFF);
    rd(A_MASK, d); chk("R10 mask untouched", d, 32'h0);
    rd(A_ACK, d);  chk("R10 ack untouched", d, 32'h0);
    rd(8'h00, d);  chk("R10 read 0x00", d, 32'h0);
    rd(8'h18, d);  chk("R10 read 0x18", d, 32'h0);
    rd(8'h20, d);  chk("R10 read 0x20", d, 32'h0);

    // flush to a known state
    wr(A_ACK, 32'hFFFF_FFFF); wr(A_ACK, 32'h0); settle(4);
    m_pend = '0; m_mask = '0;

    // R6 simultaneous sources, random mix
    for (int i = 0; i < 40; i++) begin
      r = $urandom & ~src;
      @(negedge clk); src = src | r;
      settle(5);
      m_pend = m_pend | r;
      m = $urandom & $urandom;
      wr(A_MASK, m); m_mask = m;
      rd(A_STAT, d); chk("R6 random status", d, exp_status(m_pend, m_mask));
      settle(1); #1 chk("R9 random irq", {31'b0, irq}, {31'b0, |exp_status(m_pend, m_mask)});
      a = $urandom & $urandom;
      wr(A_ACK, a); wr(A_ACK, 32'h0);
      m_pend = m_pend & ~a;
      rd(A_STAT, d); chk("R7 random ack", d, exp_status(m_pend, m_mask));
      @(negedge clk); src = src & ~$urandom;
      settle(4);
    end

    finish_run();
  end
endmodule